// File: doc/BRIEF.md
# Parallel Printer Port Byte Transmitter

This block sends bytes from a host to a printer over a classic eight-bit parallel printer port. The host offers a byte with a valid/ready pair. The block drives the byte onto the data lines at once, before the printer reports that it is free. It then waits for the printer's busy line to fall and for a programmable data setup time to pass. It issues one active-low strobe pulse of fixed width and keeps the data unchanged for a hold time after the strobe returns high. Every interval is a count of clock cycles, derived by default from the clock frequency. The defaults are 10 us of setup, 2 us of strobe, 1 us of hold and a 1 ms busy limit. These margins are well above the printer's nominal minimums, so that slow, heavily filtered cable edges still meet the limits at the far end.

The valid/ready handshake marks the commit point. Ready is high only in the cycle before the strobe falls, so a byte is consumed exactly when its strobe starts. The host must hold the byte and valid until then. An abort during the wait discards nothing: the offered byte stays pending and is sent once it is offered again. If the busy line stays high past the limit, a sticky timeout flag rises and no strobe is issued. The acknowledge input is synchronised, and each falling edge on it sets a sticky flag that the host clears.

Top module: `ppt_tx`

## Requirements
- R1: After reset the strobe output is high, the data bus is 0x00, and in_ready, timeout and ack_seen are low.
- R2: Each byte transferred by in_valid and in_ready is on the data bus when its strobe falls. Exactly one strobe is issued per transferred byte, in transfer order.
- R3: The data bus is stable for at least SETUP_CYC clock cycles before every strobe falling edge. This is exactly SETUP_CYC cycles when busy is low throughout.
- R4: Every strobe low pulse lasts exactly STB_CYC clock cycles.
- R5: After a strobe rising edge, the data bus does not change for at least HOLD_CYC clock cycles.
- R6: A byte offered while the block is idle appears on the data bus on the next clock edge, even while busy is high.
- R7: No strobe falls while the synchronised busy is high. Busy passes through a SYNC_STAGES-flop synchroniser (two by default).
- R8: If the synchronised busy stays high for TMO_CYC consecutive cycles while a byte waits, timeout goes high, no strobe is issued and in_ready stays low.
- R9: in_ready is high only in the cycle before a strobe falling edge. The transfer is the commit of that byte.
- R10: abort returns a waiting or timed-out block to idle without consuming the byte. abort has no effect once the strobe has begun: the pulse width and hold are unchanged.
- R11: A falling edge on the synchronised ack_n_in sets ack_seen, which stays set until ack_clr. A new edge in the same cycle as ack_clr wins.
- R12: timeout stays high after busy falls and clears only through abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte offered by the host |
| in_valid | input | 1 | Host holds a byte; must stay high until in_ready |
| in_ready | output | 1 | Commit: byte consumed on this edge, strobe follows |
| abort | input | 1 | Abandon the wait or the timeout state |
| pd_out | output | 8 | Printer data bus |
| strobe_n | output | 1 | Active-low data strobe, registered |
| busy_in | input | 1 | Printer busy, asynchronous |
| ack_n_in | input | 1 | Printer acknowledge, active low, asynchronous |
| ack_clr | input | 1 | Clears ack_seen |
| ack_seen | output | 1 | Sticky acknowledge flag |
| timeout | output | 1 | Busy stayed high beyond the limit |

## Verification
The bench first sends a back-to-back stream with busy low. This exercises the direct hold-to-setup path, where exact setup, pulse width and hold show up as cycle-exact counts. It then offers a byte with busy held high, which shows the preloaded data waiting on the bus and the strobe held back until busy clears. An abort during the wait and another during the strobe tell a discarded wait from an ignored late abort. A long busy period separates the timeout path and its sticky release. An acknowledge pulse followed by a clear covers the flag.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_TMO    = 3'd4
   } ppt_state_e;
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ppt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ppt_cnt.sv
module ppt_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != '1)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ppt_tx.sv
module ppt_tx #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SETUP_CYC   = CLK_HZ / 100_000,
   parameter int STB_CYC     = CLK_HZ / 500_000,
   parameter int HOLD_CYC    = CLK_HZ / 1_000_000,
   parameter int TMO_CYC     = CLK_HZ / 1_000,
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] in_data,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          abort,
   output logic [DW-1:0] pd_out,
   output logic          strobe_n,
   input  logic          busy_in,
   input  logic          ack_n_in,
   input  logic          ack_clr,
   output logic          ack_seen,
   output logic          timeout
);
   import ppt_pkg::*;

   localparam int PH_A   = (SETUP_CYC > STB_CYC) ? SETUP_CYC : STB_CYC;
   localparam int PH_MAX = (PH_A > HOLD_CYC) ? PH_A : HOLD_CYC;
   localparam int PW     = $clog2(PH_MAX + 1);
   localparam int TW     = $clog2(TMO_CYC + 1);
   localparam logic [PW-1:0] SETUP_LAST = PW'(SETUP_CYC - 1);
   localparam logic [PW-1:0] STB_LAST   = PW'(STB_CYC - 1);
   localparam logic [PW-1:0] HOLD_LAST  = PW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] TMO_LAST   = TW'(TMO_CYC - 1);

   if (SETUP_CYC < 1 || STB_CYC < 1 || HOLD_CYC < 1 || TMO_CYC < 1) begin : g_bad_cnt
      $error("ppt_tx: every interval needs at least one cycle");
   end
   if (STB_CYC > CLK_HZ / 200_000) begin : g_bad_stb
      $error("ppt_tx: strobe pulse longer than 5 us");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ppt_tx: DW must be positive");
   end

   ppt_state_e      state, nxt;
   logic            busy_s, ack_s, ack_q;
   logic [PW-1:0]   pcnt;
   logic [TW-1:0]   bcnt;
   logic            load, go, phase_clr, busy_clr;

   ppt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_busy_sync (
      .clk(clk), .rst_n(rst_n), .d(busy_in), .q(busy_s));
   ppt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_n_in), .q(ack_s));

   ppt_cnt #(.W(PW)) u_phase_cnt (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr), .cnt(pcnt));
   ppt_cnt #(.W(TW)) u_busy_cnt (
      .clk(clk), .rst_n(rst_n), .clr(busy_clr), .cnt(bcnt));

   assign go       = (state == ST_SETUP) && (pcnt >= SETUP_LAST) && !busy_s && !abort;
   assign in_ready = go;
   assign busy_clr = !((state == ST_SETUP) && busy_s);

   always_comb begin
      nxt  = state;
      load = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (in_valid && !abort) begin
               nxt  = ST_SETUP;
               load = 1'b1;
            end
         end
         ST_SETUP: begin
            if (abort)                          nxt = ST_IDLE;
            else if (go)                        nxt = ST_STROBE;
            else if (busy_s && bcnt >= TMO_LAST) nxt = ST_TMO;
         end
         ST_STROBE: begin
            if (pcnt >= STB_LAST) nxt = ST_HOLD;
         end
         ST_HOLD: begin
            if (pcnt >= HOLD_LAST) begin
               if (in_valid) begin
                  nxt  = ST_SETUP;
                  load = 1'b1;
               end else begin
                  nxt = ST_IDLE;
               end
            end
         end
         ST_TMO: begin
            if (abort) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign phase_clr = (nxt != state) || load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pd_out   <= '0;
         strobe_n <= 1'b1;
         ack_q    <= 1'b1;
         ack_seen <= 1'b0;
      end else begin
         state    <= nxt;
         strobe_n <= (nxt != ST_STROBE);
         if (load) pd_out <= in_data;
         ack_q    <= ack_s;
         if (ack_q && !ack_s) ack_seen <= 1'b1;
         else if (ack_clr)    ack_seen <= 1'b0;
      end
   end

   assign timeout = (state == ST_TMO);
endmodule

// File: rtl/ppt_tx_chk.sv
module ppt_tx_chk #(
   parameter int SETUP_CYC = 8,
   parameter int STB_CYC   = 4,
   parameter int HOLD_CYC  = 3,
   parameter int DW        = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] pd_out,
   input logic          strobe_n,
   input logic          busy_s,
   input logic          in_valid,
   input logic          in_ready,
   input logic          timeout
);
   localparam int SW = $clog2(SETUP_CYC + 2);
   localparam int LW = $clog2(STB_CYC + 2);
   localparam int HW = $clog2(HOLD_CYC + 2);

   logic [DW-1:0] pd_q;
   logic          stb_q;
   logic [SW-1:0] setup_cnt;
   logic [LW-1:0] low_cnt;
   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q      <= '0;
         stb_q     <= 1'b1;
         setup_cnt <= SW'(SETUP_CYC);
         low_cnt   <= '0;
         hold_cnt  <= HW'(HOLD_CYC);
      end else begin
         pd_q  <= pd_out;
         stb_q <= strobe_n;
         if (pd_out != pd_q)                 setup_cnt <= SW'(1);
         else if (setup_cnt < SW'(SETUP_CYC)) setup_cnt <= setup_cnt + 1'b1;
         if (strobe_n)                        low_cnt <= '0;
         else if (low_cnt <= LW'(STB_CYC))    low_cnt <= low_cnt + 1'b1;
         if (strobe_n && !stb_q)              hold_cnt <= HW'(1);
         else if (hold_cnt < HW'(HOLD_CYC))   hold_cnt <= hold_cnt + 1'b1;
      end
   end

   AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_n) |-> setup_cnt >= SW'(SETUP_CYC)); // R3
   AST_STB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_n) |-> low_cnt == LW'(STB_CYC)); // R4
   AST_STB_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LW'(STB_CYC)); // R4
   AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_out != $past(pd_out)) |-> (strobe_n && hold_cnt >= HW'(HOLD_CYC))); // R5
   AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_n) |-> !$past(busy_s)); // R7
   AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> $fell(strobe_n)); // R9
   AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (strobe_n && !in_ready)); // R8
endmodule

bind ppt_tx ppt_tx_chk #(
   .SETUP_CYC(SETUP_CYC), .STB_CYC(STB_CYC), .HOLD_CYC(HOLD_CYC), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pd_out(pd_out), .strobe_n(strobe_n),
   .busy_s(busy_s), .in_valid(in_valid), .in_ready(in_ready), .timeout(timeout)
);

// File: tb/ppt_tx_test.sv
module ppt_tx_test;
   localparam int SETUP_C = 8;
   localparam int STB_C   = 4;
   localparam int HOLD_C  = 3;
   localparam int TMO_C   = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       abort = 1'b0;
   logic [7:0] pd_out;
   logic       strobe_n;
   logic       busy_in = 1'b0;
   logic       ack_n_in = 1'b1;
   logic       ack_clr = 1'b0;
   logic       ack_seen;
   logic       timeout;

   int checks = 0;
   int failures = 0;
   int pushes = 0;
   int falls = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   ppt_tx #(.CLK_HZ(250_000_000), .SETUP_CYC(SETUP_C), .STB_CYC(STB_C),
            .HOLD_CYC(HOLD_C), .TMO_CYC(TMO_C)) uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .abort(abort), .pd_out(pd_out), .strobe_n(strobe_n),
      .busy_in(busy_in), .ack_n_in(ack_n_in), .ack_clr(ack_clr),
      .ack_seen(ack_seen), .timeout(timeout));

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_commit();
      do @(negedge clk); while (!in_ready);
      exp_q.push_back(in_data);
      pushes++;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(posedge clk);
      #1 in_valid = 1'b1;
      in_data = b;
      wait_commit();
   endtask

   // scoreboard monitor: timing and order of every strobe
   initial begin
      logic       prev_stb = 1'b1;
      logic [7:0] last_pd = 8'h00;
      logic       exp_fall = 1'b0;
      logic       fall;
      int stab = 100, low = 0, hi = 100, busy_hi = 0;
      logic [7:0] e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            fall = prev_stb && !strobe_n;
            if (pd_out != last_pd) begin
               check(strobe_n && hi >= HOLD_C, "R5 hold before bus change", hi, HOLD_C);
               stab = 1;
            end else stab++;
            if (exp_fall) check(fall, "R9 ready not followed by strobe", int'(fall), 1);
            exp_fall = in_ready;
            if (fall) begin
               falls++;
               check(stab >= SETUP_C + 1, "R3 setup", stab - 1, SETUP_C);
               check(busy_hi < 3, "R7 strobe while busy", busy_hi, 0);
               if (exp_q.size() == 0) check(1'b0, "R2 unexpected strobe", pd_out, -1);
               else begin
                  e = exp_q.pop_front();
                  check(pd_out == e, "R2 strobed byte", pd_out, e);
               end
               low = 1;
            end else if (!strobe_n) low++;
            if (!prev_stb && strobe_n) begin
               check(low == STB_C, "R4 strobe width", low, STB_C);
               hi = 1;
            end else if (strobe_n && hi < 100) hi++;
            busy_hi = busy_in ? busy_hi + 1 : 0;
            last_pd = pd_out;
            prev_stb = strobe_n;
         end
      end
   end

   initial begin
      repeat (100_000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(strobe_n == 1'b1, "R1 strobe idle", strobe_n, 1);
      check(pd_out == 8'h00, "R1 data bus", pd_out, 0);
      check(!in_ready && !timeout && !ack_seen, "R1 flags", {in_ready, timeout, ack_seen}, 0);

      // R2 R3 R4 R5: back-to-back stream, busy low
      send(8'hA5);
      send(8'h3C);
      send(8'hFF);
      send(8'h00);
      repeat (20) @(posedge clk);

      // R6 R7: preload while busy high
      #1 busy_in = 1'b1;
      in_valid = 1'b1;
      in_data = 8'h96;
      @(posedge clk);
      @(negedge clk);
      check(pd_out == 8'h96, "R6 preload next edge", pd_out, 8'h96);
      repeat (12) @(negedge clk);
      check(strobe_n == 1'b1, "R7 held by busy", strobe_n, 1);
      check(in_ready == 1'b0, "R9 no ready while busy", in_ready, 0);
      @(posedge clk);
      #1 busy_in = 1'b0;
      wait_commit();
      repeat (15) @(posedge clk);

      // R10: abort while waiting keeps byte pending
      #1 busy_in = 1'b1;
      in_valid = 1'b1;
      in_data = 8'h5A;
      repeat (4) @(posedge clk);
      #1 abort = 1'b1;
      @(posedge clk);
      #1 abort = 1'b0;
      repeat (3) @(negedge clk);
      check(strobe_n && !timeout, "R10 abort in setup no strobe", strobe_n, 1);
      @(posedge clk);
      #1 busy_in = 1'b0;
      wait_commit();
      repeat (2) @(posedge clk);

      // R10: abort during strobe is ignored (width checked by monitor)
      #1 abort = 1'b1;
      repeat (3) @(posedge clk);
      #1 abort = 1'b0;
      send(8'h11);
      #1 abort = 1'b1;
      @(posedge clk);
      #1 abort = 1'b0;
      repeat (15) @(posedge clk);

      // R8 R12: timeout
      #1 busy_in = 1'b1;
      in_valid = 1'b1;
      in_data = 8'hC3;
      repeat (TMO_C + 10) @(posedge clk);
      @(negedge clk);
      check(timeout == 1'b1, "R8 timeout raised", timeout, 1);
      check(strobe_n && !in_ready, "R8 no strobe in timeout", strobe_n, 1);
      @(posedge clk);
      #1 busy_in = 1'b0;
      repeat (6) @(negedge clk);
      check(timeout == 1'b1, "R12 timeout sticky", timeout, 1);
      @(posedge clk);
      #1 abort = 1'b1;
      @(posedge clk);
      #1 abort = 1'b0;
      @(negedge clk);
      check(timeout == 1'b0, "R12 timeout cleared by abort", timeout, 0);
      wait_commit();
      repeat (15) @(posedge clk);

      // R11: acknowledge flag
      #1 ack_clr = 1'b1;
      @(posedge clk);
      #1 ack_clr = 1'b0;
      @(negedge clk);
      check(ack_seen == 1'b0, "R11 clear without edge", ack_seen, 0);
      @(posedge clk);
      #1 ack_n_in = 1'b0;
      repeat (3) @(posedge clk);
      #1 ack_n_in = 1'b1;
      repeat (4) @(negedge clk);
      check(ack_seen == 1'b1, "R11 ack latched", ack_seen, 1);
      repeat (5) @(negedge clk);
      check(ack_seen == 1'b1, "R11 ack sticky", ack_seen, 1);
      @(posedge clk);
      #1 ack_clr = 1'b1;
      @(posedge clk);
      #1 ack_clr = 1'b0;
      @(negedge clk);
      check(ack_seen == 1'b0, "R11 ack cleared", ack_seen, 0);

      repeat (20) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R2 all bytes strobed", exp_q.size(), 0);
      check(falls == pushes, "R2 one strobe per byte", falls, pushes);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule